// File: doc/BRIEF.md
# Integer exception status register

This block keeps the integer exception status word of a processor core and updates its flags after each integer instruction retires. The execute stage presents an instruction class code, an overflow-enable flag, the adder carries out of the two most-significant bit positions, and, for arithmetic right shifts, the sign of the shift source and the bits shifted out. On the next clock edge the block applies the flag rules for that class. The carries must describe the complete operation (for a three-term subtract-from-carrying, the carries of the whole sum), so no intermediate sum ever reaches a flag.

Software reads the whole word and writes it through a plain read/write port. A write loads the three flags, a retained spare byte and the 7-bit string byte count. Every other reserved bit drops the write and reads as zero. The summary-overflow flag collects every overflow and stays set until software clears it. Reset leaves the stored word as it is.

Top module: `int_exc_status`

## Requirements
- R1: Bit 0 is the most-significant bit of `sw_rdata`. Summary overflow (SO) reads at bit 0 (vector index 31), overflow (OV) at bit 1 (index 30), carry (CA) at bit 2 (index 29), the spare byte at bits 16 to 23 (indices 15:8) and the byte count at bits 25 to 31 (indices 6:0). Every other bit reads 0.
- R2: With class code 2'b01 (arithmetic) and `ov_en` high, OV becomes `carry_msb` XOR `carry_next` on the next edge. This covers the signed extremes.
- R3: When an arithmetic instruction sets OV, SO is set on the same edge. SO then stays 1 through later instructions, including ones that clear OV, until a software write loads 0.
- R4: With class 2'b01, CA becomes `carry_msb` whatever `ov_en` is. With `ov_en` low, OV and SO are left unchanged.
- R5: With class code 2'b10 (arithmetic right shift), CA becomes 1 only when `shr_sign` is 1 and `shr_lost` has at least one 1 bit, and becomes 0 otherwise. OV and SO are left unchanged.
- R6: Class codes 2'b11 (compare) and 2'b00 (no update) leave the whole word unchanged, whatever the carry inputs are.
- R7: Instructions never change the spare byte or the byte count. A software write loads SO, OV, CA, the spare byte and the byte count from the matching `sw_wdata` bits and drops every other bit.
- R8: When a software write and an instruction update fall in the same cycle, the written value wins.
- R9: While `rst` is high, the stored word keeps its value. Neither a software write nor an instruction update changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset. It holds the stored word unchanged |
| xcls | input | 2 | Instruction class: 00 none, 01 arithmetic, 10 shift-algebraic, 11 compare |
| ov_en | input | 1 | Overflow enable of the arithmetic instruction |
| carry_msb | input | 1 | Carry out of bit 0 (the MSB) for the whole operation |
| carry_next | input | 1 | Carry out of bit 1 for the whole operation |
| shr_sign | input | 1 | Sign bit of the shift source |
| shr_lost | input | LOST_W | Bits shifted out by the arithmetic right shift, zero-filled |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current register word |

## Verification
The bench builds the block with the default `LOST_W` of 32. At that width a shift can lose any number of bits from one up to the full word, so a single lost 1 at either end of the vector, and an all-zero loss from a negative source, are both reachable. The adder carries are derived in the bench from 32-bit operands and a carry-in. The random operands, together with the directed operands 0x7FFFFFFF and 0x80000000, reach both signed overflow directions and three-term subtracts that overflow.

// File: rtl/int_exc_pkg.sv
package int_exc_pkg;

    localparam int XR_W      = 32;
    localparam int CNT_W     = 7;
    localparam int SPARE_W   = 8;

    // vector indices (architectural bit 0 is vector index XR_W-1)
    localparam int SO_IDX    = XR_W - 1;
    localparam int OV_IDX    = XR_W - 2;
    localparam int CA_IDX    = XR_W - 3;
    localparam int SPARE_LSB = XR_W - 24;
    localparam int CNT_LSB   = 0;

    localparam logic [XR_W-1:0] KEEP_MASK =
        (XR_W'(1) << SO_IDX) | (XR_W'(1) << OV_IDX) | (XR_W'(1) << CA_IDX) |
        (XR_W'((1 << SPARE_W) - 1) << SPARE_LSB) |
        (XR_W'((1 << CNT_W) - 1) << CNT_LSB);

    typedef enum logic [1:0] {
        CLS_NONE  = 2'b00,
        CLS_ARITH = 2'b01,
        CLS_SHRA  = 2'b10,
        CLS_CMP   = 2'b11
    } xcls_e;

    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } xflags_t;

    typedef struct packed {
        xflags_t              flags;
        logic [SPARE_W-1:0]   spare;
        logic [CNT_W-1:0]     cnt;
    } xstate_t;

    function automatic xstate_t word_to_state(logic [XR_W-1:0] w);
        xstate_t s;
        s.flags.so = w[SO_IDX];
        s.flags.ov = w[OV_IDX];
        s.flags.ca = w[CA_IDX];
        s.spare    = w[SPARE_LSB +: SPARE_W];
        s.cnt      = w[CNT_LSB +: CNT_W];
        return s;
    endfunction

    function automatic logic [XR_W-1:0] state_to_word(xstate_t s);
        logic [XR_W-1:0] w;
        w = '0;
        w[SO_IDX] = s.flags.so;
        w[OV_IDX] = s.flags.ov;
        w[CA_IDX] = s.flags.ca;
        w[SPARE_LSB +: SPARE_W] = s.spare;
        w[CNT_LSB +: CNT_W]     = s.cnt;
        return w;
    endfunction

endpackage

// File: rtl/iex_flag_gen.sv
module iex_flag_gen
    import int_exc_pkg::*;
#(
    parameter int LOST_W = 32
) (
    input  xcls_e              cls,
    input  logic               ov_en,
    input  logic               carry_msb,
    input  logic               carry_next,
    input  logic               shr_sign,
    input  logic [LOST_W-1:0]  shr_lost,
    input  xflags_t            cur,
    output xflags_t            nxt
);

    logic signed_ovf;
    logic lost_one;

    assign signed_ovf = carry_msb ^ carry_next;
    assign lost_one   = |shr_lost;

    always_comb begin
        nxt = cur;
        unique case (cls)
            CLS_ARITH: begin
                nxt.ca = carry_msb;
                if (ov_en) begin
                    nxt.ov = signed_ovf;
                    nxt.so = cur.so | signed_ovf;
                end
            end
            CLS_SHRA: begin
                nxt.ca = shr_sign & lost_one;
            end
            default: begin
                nxt = cur;
            end
        endcase
    end

endmodule

// File: rtl/iex_reg_store.sv
module iex_reg_store
    import int_exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_wr,
    input  logic [XR_W-1:0]  sw_word,
    input  xflags_t          ins_flags,
    output xstate_t          state
);

    xstate_t st_q;

    // reset holds the contents; software write beats the instruction update
    always_ff @(posedge clk) begin
        if (!rst) begin
            if (sw_wr) begin
                st_q <= word_to_state(sw_word);
            end else begin
                st_q.flags <= ins_flags;
            end
        end
    end

    assign state = st_q;

endmodule

// File: rtl/int_exc_status.sv
module int_exc_status
    import int_exc_pkg::*;
#(
    parameter int LOST_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         xcls,
    input  logic               ov_en,
    input  logic               carry_msb,
    input  logic               carry_next,
    input  logic               shr_sign,
    input  logic [LOST_W-1:0]  shr_lost,
    input  logic               sw_wr,
    input  logic [XR_W-1:0]    sw_wdata,
    output logic [XR_W-1:0]    sw_rdata
);

    xcls_e   cls;
    xstate_t state;
    xflags_t nxt_flags;

    assign cls = xcls_e'(xcls);

    iex_flag_gen #(.LOST_W(LOST_W)) u_flag_gen (
        .cls        (cls),
        .ov_en      (ov_en),
        .carry_msb  (carry_msb),
        .carry_next (carry_next),
        .shr_sign   (shr_sign),
        .shr_lost   (shr_lost),
        .cur        (state.flags),
        .nxt        (nxt_flags)
    );

    iex_reg_store u_store (
        .clk       (clk),
        .rst       (rst),
        .sw_wr     (sw_wr),
        .sw_word   (sw_wdata),
        .ins_flags (nxt_flags),
        .state     (state)
    );

    assign sw_rdata = state_to_word(state);

    p_ov_from_carries_r2: assert property (@(posedge clk) disable iff (rst)
        (xcls == 2'b01 && ov_en && !sw_wr) |=> sw_rdata[OV_IDX] == $past(carry_msb ^ carry_next));

    p_so_set_on_ov_r3: assert property (@(posedge clk) disable iff (rst)
        (xcls == 2'b01 && ov_en && !sw_wr && (carry_msb != carry_next)) |=> sw_rdata[SO_IDX]);

    p_so_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr && sw_rdata[SO_IDX]) |=> sw_rdata[SO_IDX]);

    p_ca_arith_r4: assert property (@(posedge clk) disable iff (rst)
        (xcls == 2'b01 && !sw_wr) |=> sw_rdata[CA_IDX] == $past(carry_msb));

    p_noe_keeps_ov_r4: assert property (@(posedge clk) disable iff (rst)
        (xcls == 2'b01 && !ov_en && !sw_wr) |=> $stable(sw_rdata[OV_IDX]) && $stable(sw_rdata[SO_IDX]));

    p_shra_ca_r5: assert property (@(posedge clk) disable iff (rst)
        (xcls == 2'b10 && !sw_wr) |=> sw_rdata[CA_IDX] == $past(shr_sign && (shr_lost != '0)));

    p_hold_word_r6: assert property (@(posedge clk) disable iff (rst)
        ((xcls == 2'b00 || xcls == 2'b11) && !sw_wr) |=> $stable(sw_rdata));

    p_fields_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr) |=> $stable(sw_rdata[SPARE_LSB +: SPARE_W]) && $stable(sw_rdata[CNT_LSB +: CNT_W]));

    p_sw_wins_r8: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> sw_rdata == $past(sw_wdata & KEEP_MASK));

endmodule

// File: tb/int_exc_status_bench.sv
`timescale 1ns/1ps
module int_exc_status_bench;

    localparam int LW = 32;
    localparam logic [31:0] KEEP = 32'hE000_FF7F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    xcls = 2'b00;
    logic          ov_en = 1'b0;
    logic          carry_msb = 1'b0;
    logic          carry_next = 1'b0;
    logic          shr_sign = 1'b0;
    logic [LW-1:0] shr_lost = '0;
    logic          sw_wr = 1'b0;
    logic [31:0]   sw_wdata = '0;
    logic [31:0]   sw_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_w = '0;

    always #2 clk = ~clk;

    int_exc_status #(.LOST_W(LW)) u_int_exc_status (
        .clk(clk), .rst(rst), .xcls(xcls), .ov_en(ov_en),
        .carry_msb(carry_msb), .carry_next(carry_next),
        .shr_sign(shr_sign), .shr_lost(shr_lost),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
    );

    function automatic logic [1:0] carries(logic [31:0] a, logic [31:0] b, logic cin);
        logic [32:0] full;
        logic [31:0] low;
        full = {1'b0, a} + {1'b0, b} + 33'(cin);
        low  = {1'b0, a[30:0]} + {1'b0, b[30:0]} + 32'(cin);
        return {full[32], low[31]};
    endfunction

    // expected word after one edge without reset
    function automatic logic [31:0] model(logic [31:0] cur, logic [1:0] c, logic oe,
                                          logic c0, logic c1, logic sg, logic [LW-1:0] lost,
                                          logic wr, logic [31:0] wd);
        logic [31:0] n;
        n = cur;
        if (wr) n = wd & KEEP;
        else if (c == 2'b01) begin
            n[29] = c0;
            if (oe) begin
                n[30] = c0 ^ c1;
                if (c0 ^ c1) n[31] = 1'b1;
            end
        end else if (c == 2'b10) begin
            n[29] = sg & (lost != '0);
        end
        return n;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
        end
    endtask

    task automatic step(string tag, logic [1:0] c, logic oe, logic [31:0] a, logic [31:0] b,
                        logic cin, logic sg, logic [LW-1:0] lost, logic wr, logic [31:0] wd);
        logic [1:0] cy;
        cy = carries(a, b, cin);
        xcls = c; ov_en = oe; carry_msb = cy[1]; carry_next = cy[0];
        shr_sign = sg; shr_lost = lost; sw_wr = wr; sw_wdata = wd;
        exp_w = model(exp_w, c, oe, cy[1], cy[0], sg, lost, wr, wd);
        @(posedge clk); #1;
        check(tag, sw_rdata, exp_w);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 R7: layout and write mask
        step("R1", 2'b00, 0, 0, 0, 0, 0, '0, 1, 32'hFFFF_FFFF);
        check("R1", sw_rdata, 32'hE000_FF7F);
        step("R7", 2'b00, 0, 0, 0, 0, 0, '0, 1, 32'h1234_5A3C);
        // R9: reset holds the word against write and instruction
        rst = 1'b1;
        xcls = 2'b01; ov_en = 1'b1; carry_msb = 1'b1; carry_next = 1'b0;
        sw_wr = 1'b1; sw_wdata = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1 check("R9", sw_rdata, exp_w);
        rst = 1'b0;
        // clear, then overflow extremes
        step("R7", 2'b00, 0, 0, 0, 0, 0, '0, 1, 32'h0000_0000);
        step("R4", 2'b01, 0, 32'h7FFF_FFFF, 32'h1, 0, 0, '0, 0, 0);
        check("R4", sw_rdata & 32'hC000_0000, 32'h0);
        step("R2", 2'b01, 1, 32'h7FFF_FFFF, 32'h1, 0, 0, '0, 0, 0);
        check("R3", sw_rdata & 32'hE000_0000, 32'hC000_0000);
        step("R3", 2'b01, 1, 32'h1, 32'h1, 0, 0, '0, 0, 0);
        check("R3", sw_rdata & 32'hE000_0000, 32'h8000_0000);
        step("R2", 2'b01, 1, 32'h8000_0000, 32'h8000_0000, 0, 0, '0, 0, 0);
        check("R2", sw_rdata & 32'hE000_0000, 32'hE000_0000);
        step("R2", 2'b01, 1, 32'hFFFF_FFFF, 32'h1, 0, 0, '0, 0, 0);
        check("R2", sw_rdata & 32'hE000_0000, 32'hA000_0000);
        // three-term subtract: 0x80000000 - 1 as a + ~b + 1
        step("R2", 2'b01, 1, 32'h8000_0000, ~32'h1, 1, 0, '0, 0, 0);
        check("R2", sw_rdata & 32'hE000_0000, 32'hE000_0000);
        step("R6", 2'b11, 1, 32'h7FFF_FFFF, 32'h1, 0, 1, '1, 0, 0);
        step("R6", 2'b00, 1, 32'hFFFF_FFFF, 32'h1, 0, 1, '1, 0, 0);
        // R5: negative shifts, zero-only losses
        step("R5", 2'b10, 0, 0, 0, 0, 1, '0, 0, 0);
        check("R5", sw_rdata[29], 1'b0);
        step("R5", 2'b10, 0, 0, 0, 0, 1, 32'h8000_0000, 0, 0);
        check("R5", sw_rdata[29], 1'b1);
        step("R5", 2'b10, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0);
        step("R5", 2'b10, 0, 0, 0, 0, 1, 32'h0000_0001, 0, 0);
        // R8: write in the same cycle as an overflowing add
        step("R8", 2'b01, 1, 32'h7FFF_FFFF, 32'h1, 0, 0, '0, 1, 32'h0000_0000);
        check("R8", sw_rdata, 32'h0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [1:0]  c;
            logic        oe, wr, cin, sg;
            logic [31:0] a, b, wd;
            logic [LW-1:0] lost;
            string tag;
            c   = 2'($urandom);
            oe  = 1'($urandom);
            wr  = ($urandom % 8) == 0;
            cin = 1'($urandom);
            sg  = 1'($urandom);
            a   = (($urandom % 4) == 0) ? 32'h7FFF_FFFF : $urandom;
            b   = (($urandom % 4) == 0) ? 32'h8000_0000 : $urandom;
            lost = (($urandom % 3) == 0) ? '0 : (LW'($urandom) >> ($urandom % LW));
            wd  = $urandom;
            if (wr) tag = "R8";
            else if (c == 2'b01 && oe) tag = "R2";
            else if (c == 2'b01) tag = "R4";
            else if (c == 2'b10) tag = "R5";
            else tag = "R6";
            step(tag, c, oe, a, b, cin, sg, lost, wr, wd);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule